// File: doc/BRIEF.md
# Bus-B Shift and Rotate Unit

This combinational unit sits between the B operand bus of a small datapath and the function-output multiplexer. It turns the word on the bus into the shifter candidate that the multiplexer can pick. In its ordinary mode a 2-bit operation code selects one of four results:

- the word unchanged,
- the word moved one place toward the least significant bit,
- the word moved one place toward the most significant bit,
- all zeros.

For the two single-place moves, two serial fill inputs supply the bit that enters the vacated position.

A second path is a barrel rotator made of one multiplexer per output bit. It turns the word left by 0 to WIDTH-1 places within the same cycle, and bits leaving the top come back in at the bottom. When the rotate enable is high, the rotator's result is sent to the output in place of the coded result. With the default 4-bit word, a left turn by three places gives the same word as a right turn by one place.

Top module: `busb_shifter`

## Requirements
- R1: With rot_en low and shift_code 2'b00, shift_out equals bus_b in the same cycle, whatever the fill inputs hold.
- R2: With rot_en low and shift_code 2'b01, shift_out is bus_b shifted right by one place, and shift_out[WIDTH-1] takes msb_fill.
- R3: With rot_en low and shift_code 2'b10, shift_out is bus_b shifted left by one place, and shift_out[0] takes lsb_fill.
- R4: With rot_en low and shift_code 2'b11, shift_out is all zeros.
- R5: With rot_en high, shift_out is bus_b rotated left by rot_amt places: bit i of the output is bus_b bit (i - rot_amt) mod WIDTH.
- R6: With rot_en high and rot_amt 0, shift_out equals bus_b.
- R7: With rot_en high and rot_amt WIDTH-1, shift_out equals bus_b rotated right by one place: {bus_b[0], bus_b[WIDTH-1:1]}.
- R8: With rot_en high, shift_code, msb_fill and lsb_fill have no effect on shift_out.
- R9: With rot_en low, rot_amt has no effect on shift_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_b | input | WIDTH | Operand word taken from the B bus |
| shift_code | input | 2 | 00 pass, 01 right one, 10 left one, 11 zero |
| msb_fill | input | 1 | Bit that enters the top position on a right shift |
| lsb_fill | input | 1 | Bit that enters the bottom position on a left shift |
| rot_en | input | 1 | High to select the rotator result |
| rot_amt | input | clog2(WIDTH) | Left rotation distance |
| shift_out | output | WIDTH | Result word sent to the function-output multiplexer |

## Verification
The hardest behaviour to reach from the ports is the wrap-around of the rotator. At the largest distance, every output bit takes its value from the far end of the multiplexer lane, and those paths are only seen when asymmetric patterns are rotated by WIDTH-1. The stimulus therefore sweeps every bus value against every distance. It compares the result with a reference that is built by repeating a one-place rotation, and it compares distance WIDTH-1 with a one-place right turn. The override rows also set a shift code and fill bits that would give a different word, so that any leak from the coded path into the output is visible.

// File: rtl/busb_shifter_pkg.sv
package busb_shifter_pkg;

    // Operation codes of the single-step path; the encoding is part of the
    // control word decoded by the surrounding datapath.
    typedef enum logic [1:0] {
        OP_PASS  = 2'b00,
        OP_RIGHT = 2'b01,
        OP_LEFT  = 2'b10,
        OP_ZERO  = 2'b11
    } shift_op_e;

    // Control bundle for the single-step path.
    typedef struct packed {
        shift_op_e op;
        logic      msb_in;
        logic      lsb_in;
    } step_ctl_t;

    // Rotator distance field width for a given word width.
    function automatic int amt_width(input int width);
        return (width > 1) ? $clog2(width) : 1;
    endfunction

endpackage

// File: rtl/busb_step.sv
module busb_step
    import busb_shifter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] din,
    input  step_ctl_t        ctl,
    output logic [WIDTH-1:0] dout
);

    always_comb begin
        unique case (ctl.op)
            OP_PASS:  dout = din;
            OP_RIGHT: dout = {ctl.msb_in, din[WIDTH-1:1]};
            OP_LEFT:  dout = {din[WIDTH-2:0], ctl.lsb_in};
            default:  dout = '0;
        endcase
    end

endmodule

// File: rtl/busb_rotator.sv
module busb_rotator #(
    parameter int WIDTH = 4,
    parameter int AMT_W = 2
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);

    localparam int LANES = 1 << AMT_W;

    // One multiplexer per output bit; lane k carries the source bit that
    // lands on this position after a left turn by k places.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [LANES-1:0] lane;
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            localparam int SRC = (((i - k) % WIDTH) + WIDTH) % WIDTH;
            assign lane[k] = din[SRC];
        end
        assign dout[i] = lane[amt];
    end

endmodule

// File: rtl/busb_select.sv
module busb_select #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] step_word,
    input  logic [WIDTH-1:0] rot_word,
    input  logic             rot_en,
    output logic [WIDTH-1:0] dout
);

    always_comb begin
        dout = rot_en ? rot_word : step_word;
    end

endmodule

// File: rtl/busb_shifter.sv
module busb_shifter
    import busb_shifter_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int AMT_W = amt_width(WIDTH)
) (
    input  logic [WIDTH-1:0] bus_b,
    input  logic [1:0]       shift_code,
    input  logic             msb_fill,
    input  logic             lsb_fill,
    input  logic             rot_en,
    input  logic [AMT_W-1:0] rot_amt,
    output logic [WIDTH-1:0] shift_out
);

    step_ctl_t        step_ctl;
    logic [WIDTH-1:0] step_word;
    logic [WIDTH-1:0] rot_word;

    always_comb begin
        step_ctl.op     = shift_op_e'(shift_code);
        step_ctl.msb_in = msb_fill;
        step_ctl.lsb_in = lsb_fill;
    end

    busb_step #(.WIDTH(WIDTH)) u_step (
        .din  (bus_b),
        .ctl  (step_ctl),
        .dout (step_word)
    );

    busb_rotator #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_rot (
        .din  (bus_b),
        .amt  (rot_amt),
        .dout (rot_word)
    );

    busb_select #(.WIDTH(WIDTH)) u_sel (
        .step_word (step_word),
        .rot_word  (rot_word),
        .rot_en    (rot_en),
        .dout      (shift_out)
    );

endmodule

// File: rtl/busb_shifter_chk.sv
module busb_shifter_chk #(
    parameter int WIDTH = 4,
    parameter int AMT_W = 2
) (
    input logic [WIDTH-1:0] bus_b,
    input logic [1:0]       shift_code,
    input logic             msb_fill,
    input logic             lsb_fill,
    input logic             rot_en,
    input logic [AMT_W-1:0] rot_amt,
    input logic [WIDTH-1:0] shift_out
);

    logic [2*WIDTH-1:0] doubled;
    logic [WIDTH-1:0]   rot_ref;

    always_comb begin
        doubled = {bus_b, bus_b} << rot_amt;
        rot_ref = doubled[2*WIDTH-1:WIDTH];
    end

    always_comb begin
        if (!rot_en && shift_code == 2'b00) begin
            // R1
            pass_thru_chk: assert (shift_out == bus_b);
        end
        if (!rot_en && shift_code == 2'b01) begin
            // R2
            right_fill_chk: assert (shift_out[WIDTH-1] == msb_fill &&
                                    shift_out[WIDTH-2:0] == bus_b[WIDTH-1:1]);
        end
        if (!rot_en && shift_code == 2'b10) begin
            // R3
            left_fill_chk: assert (shift_out[0] == lsb_fill &&
                                   shift_out[WIDTH-1:1] == bus_b[WIDTH-2:0]);
        end
        if (!rot_en && shift_code == 2'b11) begin
            // R4
            zero_code_chk: assert (shift_out == '0);
        end
        if (rot_en) begin
            // R5
            rotate_left_chk: assert (shift_out == rot_ref);
        end
        if (rot_en && rot_amt == '0) begin
            // R6
            rotate_zero_chk: assert (shift_out == bus_b);
        end
        if (rot_en && int'(rot_amt) == WIDTH - 1) begin
            // R7
            rotate_wrap_chk: assert (shift_out == {bus_b[0], bus_b[WIDTH-1:1]});
        end
    end

endmodule

bind busb_shifter busb_shifter_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
    .bus_b      (bus_b),
    .shift_code (shift_code),
    .msb_fill   (msb_fill),
    .lsb_fill   (lsb_fill),
    .rot_en     (rot_en),
    .rot_amt    (rot_amt),
    .shift_out  (shift_out)
);

// File: tb/busb_shifter_bench.sv
module busb_shifter_bench;

    localparam int W  = 4;
    localparam int AW = 2;
    localparam int NV = 17;

    typedef struct packed {
        logic [W-1:0]  b;
        logic [1:0]    code;
        logic          mi;
        logic          li;
        logic          en;
        logic [AW-1:0] amt;
        logic [W-1:0]  exp;
        logic [3:0]    req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'b1011, 2'b00, 1'b0, 1'b0, 1'b0, 2'd0, 4'b1011, 4'd1}, // R1
        '{4'b0110, 2'b00, 1'b1, 1'b1, 1'b0, 2'd0, 4'b0110, 4'd1}, // R1 fills ignored
        '{4'b1011, 2'b01, 1'b0, 1'b1, 1'b0, 2'd0, 4'b0101, 4'd2}, // R2
        '{4'b1011, 2'b01, 1'b1, 1'b0, 1'b0, 2'd0, 4'b1101, 4'd2}, // R2
        '{4'b1011, 2'b10, 1'b1, 1'b0, 1'b0, 2'd0, 4'b0110, 4'd3}, // R3
        '{4'b1011, 2'b10, 1'b0, 1'b1, 1'b0, 2'd0, 4'b0111, 4'd3}, // R3
        '{4'b1111, 2'b11, 1'b1, 1'b1, 1'b0, 2'd0, 4'b0000, 4'd4}, // R4
        '{4'b1001, 2'b00, 1'b0, 1'b0, 1'b1, 2'd1, 4'b0011, 4'd5}, // R5
        '{4'b1001, 2'b00, 1'b0, 1'b0, 1'b1, 2'd2, 4'b0110, 4'd5}, // R5
        '{4'b1101, 2'b00, 1'b0, 1'b0, 1'b1, 2'd0, 4'b1101, 4'd6}, // R6
        '{4'b1001, 2'b00, 1'b0, 1'b0, 1'b1, 2'd3, 4'b1100, 4'd7}, // R7
        '{4'b0110, 2'b00, 1'b0, 1'b0, 1'b1, 2'd3, 4'b0011, 4'd7}, // R7
        '{4'b1000, 2'b11, 1'b1, 1'b1, 1'b1, 2'd2, 4'b0010, 4'd8}, // R8
        '{4'b0100, 2'b01, 1'b1, 1'b1, 1'b1, 2'd1, 4'b1000, 4'd8}, // R8
        '{4'b0100, 2'b10, 1'b1, 1'b1, 1'b1, 2'd0, 4'b0100, 4'd8}, // R8
        '{4'b0100, 2'b01, 1'b0, 1'b0, 1'b0, 2'd3, 4'b0010, 4'd9}, // R9
        '{4'b1110, 2'b00, 1'b0, 1'b0, 1'b0, 2'd2, 4'b1110, 4'd9}  // R9
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  bus_b = '0;
    logic [1:0]    shift_code = '0;
    logic          msb_fill = 1'b0;
    logic          lsb_fill = 1'b0;
    logic          rot_en = 1'b0;
    logic [AW-1:0] rot_amt = '0;
    logic [W-1:0]  shift_out;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    busb_shifter #(.WIDTH(W)) u_busb_shifter (
        .bus_b      (bus_b),
        .shift_code (shift_code),
        .msb_fill   (msb_fill),
        .lsb_fill   (lsb_fill),
        .rot_en     (rot_en),
        .rot_amt    (rot_amt),
        .shift_out  (shift_out)
    );

    task automatic drive(input logic [W-1:0] b, input logic [1:0] code,
                         input logic mi, input logic li, input logic en,
                         input logic [AW-1:0] amt);
        @(posedge clk);
        bus_b      = b;
        shift_code = code;
        msb_fill   = mi;
        lsb_fill   = li;
        rot_en     = en;
        rot_amt    = amt;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [W-1:0] exp);
        total++;
        if (shift_out !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, shift_out, exp);
        end
    endtask

    function automatic logic [W-1:0] rotl1(input logic [W-1:0] v);
        return {v[W-2:0], v[W-1]};
    endfunction

    initial begin
        // Quiet state while reset is held: zero inputs give a zero result (R1).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset-state", '0);
        rst = 1'b0;

        for (int n = 0; n < NV; n++) begin
            drive(VECS[n].b, VECS[n].code, VECS[n].mi, VECS[n].li,
                  VECS[n].en, VECS[n].amt);
            check($sformatf("R%0d vector %0d", VECS[n].req, n), VECS[n].exp);
        end

        // R5: every word against every distance, reference by repeated single turns.
        for (int b = 0; b < (1 << W); b++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                logic [W-1:0] ref_v;
                ref_v = W'(b);
                for (int s = 0; s < a; s++) ref_v = rotl1(ref_v);
                drive(W'(b), 2'b11, 1'b1, 1'b1, 1'b1, AW'(a));
                check("R5 sweep", ref_v);
            end
        end

        // R7: farthest left turn against a one-place right turn, all words.
        for (int b = 0; b < (1 << W); b++) begin
            logic [W-1:0] bv;
            bv = W'(b);
            drive(bv, 2'b01, 1'b0, 1'b0, 1'b1, AW'(W - 1));
            check("R7 wrap", {bv[0], bv[W-1:1]});
        end

        // R9: rotate distance swept while disabled, left shift selected.
        for (int a = 0; a < (1 << AW); a++) begin
            drive(4'b1001, 2'b10, 1'b0, 1'b0, 1'b0, AW'(a));
            check("R9 amt ignored", 4'b0010);
        end

        // R2/R3 edge: fills of all-ones into an all-zero word.
        drive(4'b0000, 2'b01, 1'b1, 1'b0, 1'b0, 2'd0);
        check("R2 msb fill only", 4'b1000);
        drive(4'b0000, 2'b10, 1'b0, 1'b1, 1'b0, 2'd0);
        check("R3 lsb fill only", 4'b0001);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule